// File: doc/BRIEF.md
# UART Receive and Transmit Status Flag Unit

This block keeps the status flags of a UART-style serial port and the logic that sets and clears them. The receive shifter tells it, with a one-cycle strobe, that a word has been assembled, and gives it the word and a noise mark from the bit sampler. The transmitter gives it a busy level and an empty level. A per-bit-time tick from the baud logic, together with the raw receive line, lets the block find an idle line. From these inputs the block holds the received data byte, a status byte and one interrupt request gated by two enable bits.

Software clears the four receive flags through a two-step sequence. It first reads the status byte, which arms every flag that is set at that moment. It then reads the data byte, which clears the armed flags. A flag that becomes set between the two reads is not armed, so it survives. If a word arrives while the previous one is still unread, the older word is kept and an overrun is flagged. The idle flag fires once after a run of high bit times, and it fires again only after a new word has been received.

Top module: `uart_stat_flags`

## Requirements
- R1: The status byte is {tx_empty, tc, rdrf, idle, ovr, noise, 0, 0}, from bit 7 down to bit 0. That places tc at bit 6, rdrf at bit 5, idle at bit 4, ovr at bit 3 and noise at bit 2.
- R2: The transmission-complete flag (tc) is 1 after reset. On every clock edge after reset it takes the inverse of tx_busy, so it shows the change one cycle after tx_busy changes.
- R3: A word_done strobe with rdrf at 0 loads word_data into rx_data and sets rdrf at that edge. If word_noise is 1 in the same cycle, the strobe also sets the noise flag.
- R4: A word_done strobe with rdrf at 1 and no clear completing in that cycle sets ovr. It leaves rx_data and rdrf unchanged, and the new word is dropped.
- R5: A stat_rd pulse arms every receive flag that is 1 in that cycle. A later data_rd pulse clears the armed flags at its edge, and any number of cycles without data_rd may pass between the two pulses. A data_rd pulse with nothing armed changes no flag.
- R6: A receive flag that becomes set after the stat_rd pulse is still set after the data_rd pulse that completes the clear.
- R7: If a data_rd pulse that clears an armed rdrf falls in the same cycle as word_done, the new word loads, rdrf stays 1 and ovr is not set.
- R8: The idle flag sets on the IDLE_BITS-th (default 10) bit_tick counted while rx_line is high. A low rx_line in any cycle restarts the count.
- R9: After reset, and after each idle detection, the idle flag cannot set again until a word_done strobe has occurred.
- R10: irq = (rx_irq_en & (rdrf | ovr)) | (idle_irq_en & idle). It is formed combinationally from registered state, so it falls in the same cycle as the flag clear.
- R11: Reset clears rdrf, idle, ovr, noise and rx_data to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rx_line | input | 1 | Receive line level |
| bit_tick | input | 1 | One-cycle pulse, once per bit time |
| word_done | input | 1 | Receive shifter has finished a word |
| word_data | input | 8 | Word from the receive shifter |
| word_noise | input | 1 | Noise was seen while this word was sampled |
| tx_busy | input | 1 | A frame is being sent |
| tx_empty | input | 1 | Transmit data register is empty (passed through to status bit 7) |
| stat_rd | input | 1 | Status byte is being read |
| data_rd | input | 1 | Data byte is being read |
| rx_irq_en | input | 1 | Enables the receive-full and overrun interrupt sources |
| idle_irq_en | input | 1 | Enables the idle interrupt source |
| status | output | 8 | Status byte |
| rx_data | output | 8 | Received data register |
| irq | output | 1 | Interrupt request |

## Verification
Two events can fall in the same cycle: a data read that completes the clear of receive-full, and the strobe of the next finished word. The bench arms the clear with a status read, then drives data_rd and word_done together in one cycle. It checks that the new word is now in the data register, that receive-full is still set and that overrun stays clear. A second pairing sends a word between the status read and the data read. There the bench checks that the newly set flags survive the clear, and that a second full sequence then removes them.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;

  typedef struct packed {
    logic rdrf;
    logic idle;
    logic ovr;
    logic noise;
  } rx_flags_t;

  localparam int unsigned NUM_RX_FLAGS = 4;

  localparam int unsigned ST_TXE_BIT   = 7;
  localparam int unsigned ST_TC_BIT    = 6;
  localparam int unsigned ST_RDRF_BIT  = 5;
  localparam int unsigned ST_IDLE_BIT  = 4;
  localparam int unsigned ST_OVR_BIT   = 3;
  localparam int unsigned ST_NOISE_BIT = 2;

endpackage

// File: rtl/ust_idle_det.sv
module ust_idle_det #(
  parameter int unsigned IDLE_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_line,
  input  logic bit_tick,
  input  logic word_done,
  input  logic clr,
  output logic idle_o
);

  localparam int unsigned CW = $clog2(IDLE_BITS + 1);
  localparam logic [CW-1:0] RUN_MAX  = CW'(IDLE_BITS);
  localparam logic [CW-1:0] RUN_LAST = CW'(IDLE_BITS - 1);

  logic [CW-1:0] run_q, run_nxt;
  logic          armed_q, armed_nxt;
  logic          idle_q, idle_nxt;
  logic          det;

  always_comb begin
    run_nxt = run_q;
    if (!rx_line)
      run_nxt = '0;
    else if (bit_tick && (run_q != RUN_MAX))
      run_nxt = run_q + 1'b1;
  end

  assign det = rx_line & bit_tick & armed_q & (run_q == RUN_LAST);

  always_comb begin
    armed_nxt = armed_q;
    if (word_done)
      armed_nxt = 1'b1;
    else if (det)
      armed_nxt = 1'b0;
    idle_nxt = det | (idle_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      armed_q <= 1'b0;
      idle_q  <= 1'b0;
    end else begin
      run_q   <= run_nxt;
      armed_q <= armed_nxt;
      idle_q  <= idle_nxt;
    end
  end

  assign idle_o = idle_q;

  AST_IDLE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_q) |-> $past(armed_q)) else $error("idle set while disarmed"); // R9
  AST_IDLE_LOW_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_line |=> !$rose(idle_q)) else $error("idle set on low line"); // R8

endmodule

// File: rtl/ust_rx_hold.sv
module ust_rx_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_done,
  input  logic [DW-1:0] word_data,
  input  logic          word_noise,
  input  logic          clr_rdrf,
  input  logic          clr_ovr,
  input  logic          clr_noise,
  output logic          rdrf_o,
  output logic          ovr_o,
  output logic          noise_o,
  output logic [DW-1:0] data_o
);

  logic [DW-1:0] data_q, data_nxt;
  logic          rdrf_q, rdrf_nxt;
  logic          ovr_q, ovr_nxt;
  logic          noise_q, noise_nxt;
  logic          load, ovr_set;

  assign load    = word_done & (~rdrf_q | clr_rdrf);
  assign ovr_set = word_done & rdrf_q & ~clr_rdrf;

  always_comb begin
    data_nxt  = load ? word_data : data_q;
    rdrf_nxt  = load | (rdrf_q & ~clr_rdrf);
    ovr_nxt   = ovr_set | (ovr_q & ~clr_ovr);
    noise_nxt = (load & word_noise) | (noise_q & ~clr_noise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      rdrf_q  <= 1'b0;
      ovr_q   <= 1'b0;
      noise_q <= 1'b0;
    end else begin
      if (load) data_q <= data_nxt;
      rdrf_q  <= rdrf_nxt;
      ovr_q   <= ovr_nxt;
      noise_q <= noise_nxt;
    end
  end

  assign rdrf_o  = rdrf_q;
  assign ovr_o   = ovr_q;
  assign noise_o = noise_q;
  assign data_o  = data_q;

  AST_LOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> rdrf_q) else $error("word did not leave rdrf set"); // R3
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && rdrf_q && !clr_rdrf) |=> $stable(data_q)) else $error("overrun replaced data"); // R4
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && rdrf_q && !clr_rdrf) |=> ovr_q) else $error("overrun not flagged"); // R4
  AST_COLLIDE_NO_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && clr_rdrf && !ovr_q && !clr_ovr) |=> !ovr_q) else $error("collision flagged overrun"); // R7

endmodule

// File: rtl/ust_clr_arm.sv
module ust_clr_arm
  import uart_stat_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      stat_rd,
  input  logic      data_rd,
  input  rx_flags_t flags_i,
  output rx_flags_t clr_o
);

  rx_flags_t arm_q, arm_nxt;

  always_comb begin
    arm_nxt = arm_q;
    if (data_rd)
      arm_nxt = stat_rd ? flags_i : '0;
    else if (stat_rd)
      arm_nxt = arm_q | flags_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= '0;
    else        arm_q <= arm_nxt;
  end

  assign clr_o = data_rd ? arm_q : '0;

  AST_CLR_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !data_rd) |=> ((arm_q & $past(flags_i)) == $past(flags_i))) else $error("set flag not armed"); // R5
  AST_CLR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rd |-> (clr_o == '0)) else $error("clear without data read"); // R5

endmodule

// File: rtl/uart_stat_flags.sv
module uart_stat_flags
  import uart_stat_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter int unsigned IDLE_BITS = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_line,
  input  logic          bit_tick,
  input  logic          word_done,
  input  logic [DW-1:0] word_data,
  input  logic          word_noise,
  input  logic          tx_busy,
  input  logic          tx_empty,
  input  logic          stat_rd,
  input  logic          data_rd,
  input  logic          rx_irq_en,
  input  logic          idle_irq_en,
  output logic [7:0]    status,
  output logic [DW-1:0] rx_data,
  output logic          irq
);

  logic [1:0] rst_sync_q;
  logic       rst_q;
  logic       tc_q, tc_nxt;
  rx_flags_t  flags, clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  assign tc_nxt = ~tx_busy;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) tc_q <= 1'b1;
    else        tc_q <= tc_nxt;
  end

  ust_idle_det #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk       (clk),
    .rst_n     (rst_q),
    .rx_line   (rx_line),
    .bit_tick  (bit_tick),
    .word_done (word_done),
    .clr       (clr.idle),
    .idle_o    (flags.idle)
  );

  ust_rx_hold #(.DW(DW)) u_hold (
    .clk        (clk),
    .rst_n      (rst_q),
    .word_done  (word_done),
    .word_data  (word_data),
    .word_noise (word_noise),
    .clr_rdrf   (clr.rdrf),
    .clr_ovr    (clr.ovr),
    .clr_noise  (clr.noise),
    .rdrf_o     (flags.rdrf),
    .ovr_o      (flags.ovr),
    .noise_o    (flags.noise),
    .data_o     (rx_data)
  );

  ust_clr_arm u_arm (
    .clk     (clk),
    .rst_n   (rst_q),
    .stat_rd (stat_rd),
    .data_rd (data_rd),
    .flags_i (flags),
    .clr_o   (clr)
  );

  always_comb begin
    status               = '0;
    status[ST_TXE_BIT]   = tx_empty;
    status[ST_TC_BIT]    = tc_q;
    status[ST_RDRF_BIT]  = flags.rdrf;
    status[ST_IDLE_BIT]  = flags.idle;
    status[ST_OVR_BIT]   = flags.ovr;
    status[ST_NOISE_BIT] = flags.noise;
  end

  assign irq = (rx_irq_en & (flags.rdrf | flags.ovr)) | (idle_irq_en & flags.idle);

  AST_TC_FOLLOW: assert property (@(posedge clk) disable iff (!rst_q)
    tx_busy |=> !tc_q) else $error("tc high while busy"); // R2
  AST_RDRF_FALL: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(flags.rdrf) |-> $past(data_rd)) else $error("rdrf fell without data read"); // R5
  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_q)
    irq |-> (flags.rdrf | flags.ovr | flags.idle)) else $error("irq with no source"); // R10
  AST_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_q)
    status[1:0] == 2'b00) else $error("unused status bits set"); // R1

endmodule

// File: tb/uart_stat_flags_tb.sv
module uart_stat_flags_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_line, bit_tick, word_done, word_noise;
  logic [7:0] word_data;
  logic       tx_busy, tx_empty, stat_rd, data_rd, rx_irq_en, idle_irq_en;
  logic [7:0] status, rx_data;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_stat_flags u_dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .bit_tick(bit_tick),
    .word_done(word_done), .word_data(word_data), .word_noise(word_noise),
    .tx_busy(tx_busy), .tx_empty(tx_empty), .stat_rd(stat_rd), .data_rd(data_rd),
    .rx_irq_en(rx_irq_en), .idle_irq_en(idle_irq_en),
    .status(status), .rx_data(rx_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_word(input logic [7:0] d, input logic nz);
    rx_line = 1'b0; cyc(1);
    word_data = d; word_noise = nz; word_done = 1'b1; cyc(1);
    word_done = 1'b0; word_noise = 1'b0; rx_line = 1'b1; cyc(1);
  endtask

  task automatic rd_stat();
    stat_rd = 1'b1; cyc(1); stat_rd = 1'b0; cyc(1);
  endtask

  task automatic rd_data();
    data_rd = 1'b1; cyc(1); data_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1; cyc(1); bit_tick = 1'b0; cyc(1);
    end
  endtask

  task automatic t_reset();
    chk("R1 reset status", status, 8'hC0);
    chk("R11 reset data", rx_data, 8'h00);
    chk("R10 reset irq", irq, 1'b0);
  endtask

  task automatic t_tc();
    tx_busy = 1'b1; cyc(1);
    chk("R2 tc busy", status[6], 1'b0);
    tx_busy = 1'b0; tx_empty = 1'b0; cyc(1);
    chk("R2 tc done", status[6], 1'b1);
    chk("R1 txe bit", status[7], 1'b0);
    tx_empty = 1'b1;
  endtask

  task automatic t_idle_after_reset();
    ticks(14);
    chk("R9 no idle before word", status[4], 1'b0);
  endtask

  task automatic t_load_clear();
    send_word(8'hA5, 1'b0);
    chk("R3 data", rx_data, 8'hA5);
    chk("R1 status after load", status, 8'hE0);
    chk("R10 irq off", irq, 1'b0);
    rx_irq_en = 1'b1; #1;
    chk("R10 irq on", irq, 1'b1);
    cyc(1);
    rd_data(); cyc(1);
    chk("R5 data read alone", status[5], 1'b1);
    rd_stat(); cyc(3);
    chk("R5 pending", status[5], 1'b1);
    data_rd = 1'b1; cyc(1);
    chk("R5 rdrf cleared", status[5], 1'b0);
    chk("R10 irq dropped", irq, 1'b0);
    data_rd = 1'b0; cyc(1);
  endtask

  task automatic t_overrun();
    send_word(8'h11, 1'b0);
    send_word(8'h22, 1'b1);
    chk("R4 data kept", rx_data, 8'h11);
    chk("R4 flags", status[5:2], 4'b1010);
    rd_stat(); rd_data(); cyc(1);
    chk("R5 clear both", status[5:2], 4'b0000);
  endtask

  task automatic t_late_flag();
    rd_stat();
    send_word(8'h44, 1'b1);
    chk("R3 noise set", status[2], 1'b1);
    rd_data(); cyc(1);
    chk("R6 late flags", status[5:2], 4'b1001);
    chk("R6 data", rx_data, 8'h44);
    rd_stat(); rd_data(); cyc(1);
    chk("R5 late cleared", status[5:2], 4'b0000);
  endtask

  task automatic t_collide();
    send_word(8'h55, 1'b0);
    rd_stat();
    word_data = 8'h66; word_done = 1'b1; data_rd = 1'b1; cyc(1);
    word_done = 1'b0; data_rd = 1'b0; cyc(1);
    chk("R7 new data", rx_data, 8'h66);
    chk("R7 rdrf ovr", status[5:3], 3'b100);
    rd_stat(); rd_data(); cyc(1);
  endtask

  task automatic t_idle();
    idle_irq_en = 1'b1; rx_irq_en = 1'b0;
    ticks(5);
    rx_line = 1'b0; cyc(1); rx_line = 1'b1;
    ticks(9);
    chk("R8 nine ticks", status[4], 1'b0);
    ticks(1);
    chk("R8 idle set", status[4], 1'b1);
    chk("R10 idle irq", irq, 1'b1);
    rd_stat(); rd_data(); cyc(1);
    chk("R5 idle cleared", status[4], 1'b0);
    ticks(20);
    chk("R9 no repeat", status[4], 1'b0);
    idle_irq_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; rx_line = 1'b1; bit_tick = 1'b0; word_done = 1'b0;
    word_data = '0; word_noise = 1'b0; tx_busy = 1'b0; tx_empty = 1'b1;
    stat_rd = 1'b0; data_rd = 1'b0; rx_irq_en = 1'b0; idle_irq_en = 1'b0;
    cyc(3); rst_n = 1'b1; cyc(4);
    t_reset();
    t_tc();
    t_idle_after_reset();
    t_load_clear();
    t_overrun();
    t_late_flag();
    t_collide();
    t_idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule